// File: doc/BRIEF.md
# Serial ADC Frame Host Controller

This block sits on the host side of a three-wire link to a 12-bit successive-approximation converter. The link uses an active-low chip select, a serial clock and a serial data line from the converter. When the host asks for a sample, the block pulls chip select low and waits out a setup interval. It then produces the serial clock from the system clock, with a half-period set by a divider input. It shifts in the returned bits most significant first, drops the two zero bits that lead every frame, and hands the remaining 12 bits to the consumer as a signed two's complement sample.

A frame's length sets its purpose. A plain read runs 14 serial clocks. A read with `cal_req` set runs 32 serial clocks, and the converter uses the extra clocks to recalibrate its offset. Right after reset the block runs a 16-clock frame by itself to calibrate the converter at power-up, and it throws away that frame's data. Between frames the block holds chip select low for a short tail after the last clock, then holds it high for an interval long enough for both the acquisition time and the minimum chip-select-high time. `busy` stays high from the start of a frame to the end of that interval.

Samples leave through a one-entry valid/ready stage. A sample stays on `smp_data` with `smp_valid` high until the cycle in which `smp_ready` is high. While a sample is waiting, the block starts no new frame, so no result is ever lost. A held `start` request is served as soon as the slot drains.

Top module: `adc_frame_host`

## Requirements
- R1: While reset is held, `cs_n` is 1, `sclk` is 0, `smp_valid` is 0 and `busy` is 1.
- R2: After reset is released, the block runs one frame of PUP_CLKS (16) serial clocks without any request, and that frame delivers no sample.
- R3: `sclk` is 0 whenever `cs_n` is 1. Every `sclk` high phase lasts max(`div_half`,1) system clocks, using the value latched when the frame starts.
- R4: At least SETUP_CYC system clocks pass between `cs_n` falling and the first `sclk` rising edge.
- R5: A frame started with `cal_req`=0 has exactly CONV_CLKS (14) serial clocks. A frame started with `cal_req`=1 has exactly CAL_CLKS (32).
- R6: `sdo` is sampled as `sclk` rises, most significant bit first. The first two of the 14 bits are dropped, and the next 12 bits, the first of them the sign bit, form `smp_data` in two's complement.
- R7: After the last `sclk` falling edge of a frame, `cs_n` stays low for at least TAIL_CYC system clocks.
- R8: `cs_n` stays high for at least max(ACQ_CYC,CSH_CYC) system clocks between frames. `busy` is high from the cycle after a frame is accepted until that interval ends, and `cs_n` is 1 whenever `busy` is 0.
- R9: While `smp_valid` is 1 and `smp_ready` is 0, `smp_data` holds its value. No frame starts while a sample is waiting, even if `start` is held.
- R10: A calibration frame also delivers its 12-bit sample, taken from its first 14 clocks.
- R11: A `start` pulse while `busy` is 1 has no effect: no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIVW | System clocks per serial-clock half period (0 acts as 1) |
| start | input | 1 | Level request for a frame, taken when idle and no sample is waiting |
| cal_req | input | 1 | Sampled with `start`: 1 selects the 32-clock calibration frame |
| busy | output | 1 | High during a frame and its closing intervals |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter, idle low |
| sdo | input | 1 | Serial data from the converter |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_data | output | RES | Signed sample |

## Verification
The assertions assume that the converter changes `sdo` only on `sclk` falling edges or when chip select falls, so the bit is stable at the system edge that raises `sclk`. They also assume that `smp_ready` may take any value in any cycle. The bench's converter model follows these rules: it updates its bit index only on those two events, and it returns zeros for the whole power-up frame. The sweep changes `smp_ready` only between frames, or on purpose to hold back a sample, and changes `div_half` and `cal_req` only while the block is idle.

// File: rtl/adcfh_pkg.sv
package adcfh_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    FR_PUP,
    FR_CONV,
    FR_CAL
  } frame_kind_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcfh_interval.sv
module adcfh_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/adcfh_shift.sv
module adcfh_shift #(
  parameter int OW = 12,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cap,
  input  logic          bit_in,
  output logic [OW-1:0] word
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] DWV = CW'(DW);

  logic [CW-1:0] taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      taken <= '0;
    end else if (clear) begin
      word  <= '0;
      taken <= '0;
    end else if (cap && taken < DWV) begin
      word  <= {word[OW-2:0], bit_in};
      taken <= taken + CW'(1);
    end
  end

  // R6
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken <= DWV);

endmodule

// File: rtl/adcfh_slot.sv
module adcfh_slot #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= push_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid);

endmodule

// File: rtl/adc_frame_host.sv
module adc_frame_host
  import adcfh_pkg::*;
#(
  parameter int RES       = 12,
  parameter int PAD       = 2,
  parameter int CONV_CLKS = 14,
  parameter int CAL_CLKS  = 32,
  parameter int PUP_CLKS  = 16,
  parameter int SETUP_CYC = 3,
  parameter int TAIL_CYC  = 2,
  parameter int ACQ_CYC   = 40,
  parameter int CSH_CYC   = 12,
  parameter int DIVW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIVW-1:0]       div_half,
  input  logic                  start,
  input  logic                  cal_req,
  output logic                  busy,
  output logic                  cs_n,
  output logic                  sclk,
  input  logic                  sdo,
  output logic                  smp_valid,
  input  logic                  smp_ready,
  output logic signed [RES-1:0] smp_data
);
  localparam int FRAME_BITS = RES + PAD;
  localparam int GAP_CYC    = imax(ACQ_CYC, CSH_CYC);
  localparam int TMAX       = imax(imax(SETUP_CYC, TAIL_CYC), imax(GAP_CYC, 2 ** DIVW));
  localparam int CNTW       = $clog2(TMAX + 1);
  localparam int ECW        = $clog2(imax(imax(CAL_CLKS, PUP_CLKS), CONV_CLKS) + 1);
  localparam logic [ECW-1:0] BITS_E = ECW'(FRAME_BITS);
  localparam logic [ECW-1:0] CONV_E = ECW'(CONV_CLKS);
  localparam logic [ECW-1:0] CAL_E  = ECW'(CAL_CLKS);
  localparam logic [ECW-1:0] PUP_E  = ECW'(PUP_CLKS);

  seq_state_e    st, st_d;
  frame_kind_e   kind, kind_d;
  logic [DIVW-1:0] half_q, half_d, eff_half;
  logic [ECW-1:0]  edges, edges_d, nclk;
  logic            cs_q, cs_d, sclk_q, sclk_d;
  logic            ld, tdone, push, sh_clr, cap;
  logic [CNTW-1:0] ld_val;
  logic [RES-1:0]  sh_word, slot_data;

  assign eff_half = (div_half == '0) ? DIVW'(1) : div_half;

  always_comb begin
    case (kind)
      FR_PUP:  nclk = PUP_E;
      FR_CAL:  nclk = CAL_E;
      default: nclk = CONV_E;
    endcase
  end

  always_comb begin
    st_d    = st;
    kind_d  = kind;
    half_d  = half_q;
    edges_d = edges;
    cs_d    = cs_q;
    sclk_d  = sclk_q;
    ld      = 1'b0;
    ld_val  = '0;
    push    = 1'b0;
    sh_clr  = 1'b0;
    cap     = 1'b0;
    case (st)
      ST_INIT, ST_IDLE: begin
        if (st == ST_INIT || (start && !smp_valid)) begin
          st_d    = ST_SETUP;
          kind_d  = (st == ST_INIT) ? FR_PUP : (cal_req ? FR_CAL : FR_CONV);
          half_d  = eff_half;
          edges_d = '0;
          cs_d    = 1'b0;
          sh_clr  = 1'b1;
          ld      = 1'b1;
          ld_val  = CNTW'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (tdone) begin
          st_d   = ST_LOW;
          ld     = 1'b1;
          ld_val = CNTW'(half_q) - CNTW'(1);
        end
      end
      ST_LOW: begin
        if (tdone) begin
          st_d   = ST_HIGH;
          sclk_d = 1'b1;
          cap    = 1'b1;
          ld     = 1'b1;
          ld_val = CNTW'(half_q) - CNTW'(1);
        end
      end
      ST_HIGH: begin
        if (tdone) begin
          sclk_d  = 1'b0;
          edges_d = edges + ECW'(1);
          push    = (edges_d == BITS_E) && (kind != FR_PUP);
          ld      = 1'b1;
          if (edges_d == nclk) begin
            st_d   = ST_TAIL;
            ld_val = CNTW'(TAIL_CYC - 1);
          end else begin
            st_d   = ST_LOW;
            ld_val = CNTW'(half_q) - CNTW'(1);
          end
        end
      end
      ST_TAIL: begin
        if (tdone) begin
          st_d   = ST_GAP;
          cs_d   = 1'b1;
          ld     = 1'b1;
          ld_val = CNTW'(GAP_CYC - 1);
        end
      end
      ST_GAP: begin
        if (tdone) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_INIT;
      kind   <= FR_PUP;
      half_q <= DIVW'(1);
      edges  <= '0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      st     <= st_d;
      kind   <= kind_d;
      half_q <= half_d;
      edges  <= edges_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
    end
  end

  adcfh_interval #(.W(CNTW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .done     (tdone)
  );

  adcfh_shift #(.OW(RES), .DW(FRAME_BITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (sh_clr),
    .cap    (cap),
    .bit_in (sdo),
    .word   (sh_word)
  );

  adcfh_slot #(.W(RES)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (sh_word),
    .valid     (smp_valid),
    .ready     (smp_ready),
    .data      (slot_data)
  );

  assign smp_data = slot_data;
  assign busy     = (st != ST_IDLE);
  assign cs_n     = cs_q;
  assign sclk     = sclk_q;

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);

  // R4
  setup_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |=> !sclk_q);

  // R7
  cs_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> $past(!sclk_q));

  // R8
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_q);

  // R5
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= nclk);

endmodule

// File: tb/adc_frame_host_bench.sv
`timescale 1ns/1ps
module adc_frame_host_bench;
  localparam int SETUP = 3;
  localparam int TAIL  = 2;
  localparam int ACQ   = 40;
  localparam int CSH   = 12;
  localparam int GAP   = (ACQ > CSH) ? ACQ : CSH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_half = 8'd2;
  logic start = 1'b0, cal_req = 1'b0, smp_ready = 1'b1;
  logic busy, cs_n, sclk, smp_valid;
  logic signed [11:0] smp_data;
  wire sdo;

  always #2.5 clk = ~clk;

  adc_frame_host #(.SETUP_CYC(SETUP), .TAIL_CYC(TAIL), .ACQ_CYC(ACQ), .CSH_CYC(CSH)) u_adc_frame_host (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .start(start), .cal_req(cal_req),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: zeros first, then value, zeros whole power-up frame
  logic [11:0] slv_val = '0;
  bit slv_pup = 1'b1, slv_seen = 1'b0;
  int slv_idx = 0;
  logic slv_bit;
  always @(negedge cs_n) begin slv_idx = 0; slv_seen = 1'b1; end
  always @(negedge sclk) if (!cs_n) slv_idx = slv_idx + 1;
  always @(posedge cs_n) if (slv_seen) slv_pup = 1'b0;
  always @* begin
    if (slv_pup || slv_idx < 2 || slv_idx > 13) slv_bit = 1'b0;
    else slv_bit = slv_val[13 - slv_idx];
  end
  assign sdo = cs_n ? 1'bz : slv_bit;

  // link monitor
  bit pcs = 1'b1, psclk = 1'b0, fr_seen = 1'b0, half_bad = 1'b0;
  int since = 0, hi_ph = 0, tail = 0, hi_cs = 0, rises = 0, last_rises = 0, frames = 0;
  int exp_half = 2;
  always @(negedge clk) if (rst_n) begin
    if (pcs && !cs_n) begin
      since = 0; rises = 0; half_bad = 1'b0;
      if (fr_seen) chk(hi_cs >= GAP, "R8 cs high gap", hi_cs, GAP);
      fr_seen = 1'b1;
    end else if (!cs_n) since++;
    if (!psclk && sclk) begin
      if (rises == 0) chk(since >= SETUP, "R4 setup", since, SETUP);
      rises++; hi_ph = 0;
    end
    if (sclk) hi_ph++;
    if (psclk && !sclk) begin
      if (hi_ph != exp_half) half_bad = 1'b1;
      tail = 1;
    end else if (!cs_n && !sclk) tail++;
    if (!pcs && cs_n) begin
      chk(tail >= TAIL, "R7 tail", tail, TAIL);
      last_rises = rises; frames++; hi_cs = 0;
    end
    if (cs_n) hi_cs++;
    if (cs_n && sclk) chk(0, "R3 sclk while cs high", 1, 0);
    pcs = cs_n; psclk = sclk;
  end

  int got_cnt = 0;
  logic [11:0] last_got = '0;
  always @(negedge clk) if (rst_n && smp_valid && smp_ready) begin
    got_cnt++; last_got = smp_data;
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic run_frame(input logic [11:0] val, input bit cal, input int half);
    int g0, clks;
    g0 = got_cnt;
    slv_val = val;
    div_half = 8'(half);
    exp_half = (half == 0) ? 1 : half;
    cal_req = cal;
    @(negedge clk) start = 1'b1;
    do @(negedge clk); while (!busy);
    start = 1'b0; cal_req = 1'b0;
    wait_idle();
    clks = cal ? 32 : 14;
    chk(last_rises == clks, cal ? "R5 cal clocks" : "R5 conv clocks", last_rises, clks);
    chk(!half_bad, "R3 half period", int'(half_bad), 0);
    chk(got_cnt == g0 + 1, "R9 one sample", got_cnt - g0, 1);
    chk(last_got == val, cal ? "R10 cal sample" : "R6 sample", int'(last_got), int'(val));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    logic [11:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(smp_valid == 1'b0, "R1 smp_valid", int'(smp_valid), 0);
    chk(busy == 1'b1, "R1 busy", int'(busy), 1);
    rst_n = 1'b1;
    wait_idle();
    // R2 power-up frame
    chk(frames == 1, "R2 frame count", frames, 1);
    chk(last_rises == 16, "R2 clocks", last_rises, 16);
    chk(got_cnt == 0, "R2 discarded", got_cnt, 0);
    chk(!half_bad, "R3 half pup", int'(half_bad), 0);

    // corners
    run_frame(12'h000, 0, 1);
    run_frame(12'h7FF, 0, 2);
    run_frame(12'h800, 0, 3);
    run_frame(12'hFFF, 1, 1);
    run_frame(12'h001, 0, 0);
    run_frame(12'hAAA, 1, 2);
    run_frame(12'h555, 0, 5);

    // sweep
    for (int i = 0; i < 512; i++) begin
      v = 12'(i * 8 + (i % 8));
      run_frame(v, (i % 64) == 5, i % 4);
    end

    // R11: start while busy is ignored
    f0 = frames;
    slv_val = 12'h321; div_half = 8'd2; exp_half = 2;
    @(negedge clk) start = 1'b1;
    do @(negedge clk); while (!busy);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (60) @(negedge clk);
    chk(frames == f0 + 1, "R11 no extra frame", frames - f0, 1);
    chk(cs_n == 1'b1, "R11 cs idle", int'(cs_n), 1);

    // R9: back-pressure
    smp_ready = 1'b0;
    f0 = frames;
    slv_val = 12'h9C3;
    @(negedge clk) start = 1'b1;
    do @(negedge clk); while (!busy);
    start = 1'b0;
    wait_idle();
    chk(smp_valid == 1'b1, "R9 held valid", int'(smp_valid), 1);
    chk(smp_data == 12'h9C3, "R9 held data", int'(smp_data), 'h9C3);
    start = 1'b1;
    slv_val = 12'h0F0;
    repeat (80) @(negedge clk);
    chk(frames == f0 + 1, "R9 no frame while pending", frames - f0, 1);
    chk(smp_data == 12'h9C3, "R9 data stable", int'(smp_data), 'h9C3);
    chk(busy == 1'b0, "R8 busy low while waiting", int'(busy), 0);
    smp_ready = 1'b1;
    do @(negedge clk); while (!busy);
    start = 1'b0;
    wait_idle();
    chk(frames == f0 + 2, "R9 frame after drain", frames - f0, 2);
    chk(last_got == 12'h0F0, "R6 after drain", int'(last_got), 'h0F0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule